// File: doc/BRIEF.md
# Serial Program Bootstrap Loader

This block fills program memory from an asynchronous serial line straight after reset. While reset is held, it latches four mode pins. Two pin patterns select serial boot. With any other pattern the loader stays idle.

When serial boot is selected, the loader receives 8N1 bytes. Their timing comes from an oversampling strobe that pulses sixteen times per bit period. The first three bytes give the program length in 24-bit words. The next three bytes give the load address. The bytes after that are packed three at a time into 24-bit words. Each word is written to consecutive program-memory addresses through a single-cycle write port.

Every byte that is accepted is sent back on the transmit line, so the host can confirm each one. Once the last word is written, the loader raises a sticky done flag and accepts no more bytes. It also presents the captured load address. The processor core then takes over.

Top module: `serial_boot_loader`

## Requirements
- R1: The mode pins are latched while rst_n is low. The loader runs only if the latched value is 4'b0010 or 4'b1010. For any other value it never echoes, never writes, keeps txd at 1 and keeps done at 0.
- R2: A frame is one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). Each bit lasts 16 pulses of os_tick.
  - A falling edge on rxd begins a frame.
  - The start bit is confirmed only if rxd is still low at the 8th strobe after that edge. A shorter low pulse is ignored.
  - Each data bit is sampled 16 strobes after the previous sample point.
- R3: Every accepted byte is retransmitted on txd as a frame in the same format and at the same bit rate. txd rests at 1. The host leaves at least one idle bit time between frames.
- R4: The first three accepted bytes form the 24-bit program length, least significant byte first.
- R5: The next three accepted bytes form the 24-bit load address, least significant byte first. start_addr holds this value from then on.
- R6: Each later group of three bytes forms one 24-bit word, least significant byte first. The word appears on mem_data with a one-cycle mem_we pulse. mem_addr is the low AW bits of the load address plus the word index (0, 1, 2, ...).
- R7: After the number of words given by the length has been written, done rises and stays at 1. Further bytes cause no write and no echo.
- R8: A length of zero raises done as soon as the third length byte is accepted. The loader then waits for no address bytes, and start_addr stays 0.
- R9: A frame whose stop bit samples 0 is discarded. It is not echoed and does not advance the byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the mode pins are latched while it is low |
| mode_pins | input | 4 | Boot mode selection pins |
| os_tick | input | 1 | One-cycle strobe at 16 times the serial bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line carrying the echo |
| mem_we | output | 1 | Program memory write strobe, one cycle per word |
| mem_addr | output | AW | Program memory write address |
| mem_data | output | 24 | Program memory write data |
| done | output | 1 | Load complete, sticky until reset |
| start_addr | output | 24 | Captured load address |

## Verification
The assertions check on every cycle that a non-boot mode keeps the loader silent and that done never falls. They also check that no write follows done, that write strobes are single-cycle, that successive writes step the address by one, and that txd rests high whenever no echo is in progress. Only the bench scenarios can show the byte-level behaviour: the ordering of the length, address and data fields, the rejection of glitches and bad stop bits, and the exact content of each echo. The bench decodes txd and compares the result, together with each memory write, against a queue-based reference on every clock.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    localparam int WORD_W         = 24;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int OS_RATE        = 16;
    localparam int FRAME_BITS     = BYTE_W + 2;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
    typedef enum logic [2:0] {CT_CHECK, CT_HALT, CT_LEN, CT_ADDR, CT_PROG, CT_DONE} ct_st_e;
endpackage

// File: rtl/sbl_rx.sv
module sbl_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      os_tick,
    input  logic                      rxd,
    output logic                      byte_valid,
    output logic [sbl_pkg::BYTE_W-1:0] byte_data
);
    import sbl_pkg::*;
    localparam int CW = $clog2(OS_RATE);
    localparam int NW = $clog2(BYTE_W);
    localparam logic [CW-1:0] CONFIRM = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] FULL    = CW'(OS_RATE - 1);
    localparam logic [NW-1:0] LAST    = NW'(BYTE_W - 1);

    typedef struct packed {
        rx_st_e              st;
        logic [CW-1:0]       cnt;
        logic [NW-1:0]       nbit;
        logic [BYTE_W-1:0]   sh;
        logic                prev;
        logic                valid;
        logic [BYTE_W-1:0]   data;
    } rx_t;

    logic [SYNC_STAGES-1:0] sync_q;
    logic rx_s;
    rx_t q, d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        d = q;
        d.valid = 1'b0;
        if (os_tick) begin
            d.prev = rx_s;
            case (q.st)
                RX_IDLE: if (q.prev && !rx_s) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
                RX_START: if (q.cnt == CONFIRM) begin
                    d.cnt  = '0;
                    d.nbit = '0;
                    d.st   = rx_s ? RX_IDLE : RX_DATA;
                end else d.cnt = q.cnt + 1'b1;
                RX_DATA: if (q.cnt == FULL) begin
                    d.cnt = '0;
                    d.sh  = {rx_s, q.sh[BYTE_W-1:1]};
                    if (q.nbit == LAST) d.st = RX_STOP;
                    else                d.nbit = q.nbit + 1'b1;
                end else d.cnt = q.cnt + 1'b1;
                default: if (q.cnt == FULL) begin
                    d.st  = RX_IDLE;
                    d.cnt = '0;
                    if (rx_s) begin
                        d.valid = 1'b1;
                        d.data  = q.sh;
                    end
                end else d.cnt = q.cnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, cnt: '0, nbit: '0, sh: '0, prev: 1'b1, valid: 1'b0, data: '0};
        else        q <= d;
    end

    assign byte_valid = q.valid;
    assign byte_data  = q.data;
endmodule

// File: rtl/sbl_tx.sv
module sbl_tx (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       os_tick,
    input  logic                       load,
    input  logic [sbl_pkg::BYTE_W-1:0] load_byte,
    output logic                       txd,
    output logic                       busy
);
    import sbl_pkg::*;
    localparam int CW = $clog2(OS_RATE);
    localparam int NW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] FULL = CW'(OS_RATE - 1);
    localparam logic [NW-1:0] LAST = NW'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [CW-1:0]         cnt;
        logic [NW-1:0]         nbit;
        logic [FRAME_BITS-1:0] sh;
        logic                  txd;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (load) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, load_byte, 1'b0};
                d.cnt  = '0;
                d.nbit = '0;
            end
        end else if (os_tick) begin
            if (q.cnt == FULL) begin
                d.cnt = '0;
                d.sh  = {1'b1, q.sh[FRAME_BITS-1:1]};
                if (q.nbit == LAST) d.busy = 1'b0;
                else                d.nbit = q.nbit + 1'b1;
            end else d.cnt = q.cnt + 1'b1;
        end
        d.txd = d.busy ? d.sh[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, cnt: '0, nbit: '0, sh: '1, txd: 1'b1};
        else        q <= d;
    end

    assign txd  = q.txd;
    assign busy = q.busy;
endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl #(
    parameter int AW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [3:0]                 mode_pins,
    input  logic                       byte_valid,
    input  logic [sbl_pkg::BYTE_W-1:0] byte_data,
    output logic                       echo_load,
    output logic [sbl_pkg::BYTE_W-1:0] echo_byte,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [sbl_pkg::WORD_W-1:0] mem_data,
    output logic                       done,
    output logic [sbl_pkg::WORD_W-1:0] start_addr,
    output logic                       boot_en
);
    import sbl_pkg::*;
    localparam int IW = $clog2(BYTES_PER_WORD);
    localparam logic [IW-1:0] IDX_LAST = IW'(BYTES_PER_WORD - 1);

    typedef struct packed {
        ct_st_e             st;
        logic [3:0]         mode;
        logic [IW-1:0]      idx;
        logic [WORD_W-1:0]  acc;
        logic [WORD_W-1:0]  len;
        logic [WORD_W-1:0]  left;
        logic [WORD_W-1:0]  addr;
        logic [WORD_W-1:0]  start;
        logic               we;
        logic [AW-1:0]      waddr;
        logic [WORD_W-1:0]  wdata;
        logic               echo;
        logic [BYTE_W-1:0]  ebyte;
    } ct_t;

    ct_t q, d;
    logic [WORD_W-1:0] word;

    assign boot_en = (q.mode == 4'b0010) || (q.mode == 4'b1010);
    assign word    = {byte_data, q.acc[WORD_W-1:BYTE_W]};

    always_comb begin
        d = q;
        d.we   = 1'b0;
        d.echo = 1'b0;
        case (q.st)
            CT_CHECK: d.st = boot_en ? CT_LEN : CT_HALT;
            CT_LEN, CT_ADDR, CT_PROG: if (byte_valid) begin
                d.echo  = 1'b1;
                d.ebyte = byte_data;
                d.acc   = word;
                if (q.idx == IDX_LAST) begin
                    d.idx = '0;
                    if (q.st == CT_LEN) begin
                        d.len = word;
                        d.st  = (word == '0) ? CT_DONE : CT_ADDR;
                    end else if (q.st == CT_ADDR) begin
                        d.start = word;
                        d.addr  = word;
                        d.left  = q.len;
                        d.st    = CT_PROG;
                    end else begin
                        d.we    = 1'b1;
                        d.wdata = word;
                        d.waddr = q.addr[AW-1:0];
                        d.addr  = q.addr + 1'b1;
                        d.left  = q.left - 1'b1;
                        if (q.left == WORD_W'(1)) d.st = CT_DONE;
                    end
                end else d.idx = q.idx + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CT_CHECK, mode: mode_pins, idx: '0, acc: '0, len: '0,
                           left: '0, addr: '0, start: '0, we: 1'b0, waddr: '0,
                           wdata: '0, echo: 1'b0, ebyte: '0};
        else        q <= d;
    end

    assign echo_load  = q.echo;
    assign echo_byte  = q.ebyte;
    assign mem_we     = q.we;
    assign mem_addr   = q.waddr;
    assign mem_data   = q.wdata;
    assign done       = (q.st == CT_DONE);
    assign start_addr = q.start;
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [3:0]                 mode_pins,
    input  logic                       os_tick,
    input  logic                       rxd,
    output logic                       txd,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [sbl_pkg::WORD_W-1:0] mem_data,
    output logic                       done,
    output logic [sbl_pkg::WORD_W-1:0] start_addr
);
    import sbl_pkg::*;

    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              echo_load;
    logic [BYTE_W-1:0] echo_byte;
    logic              tx_busy;
    logic              boot_en;

    sbl_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .byte_valid(rx_valid), .byte_data(rx_byte)
    );

    sbl_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .byte_valid(rx_valid), .byte_data(rx_byte),
        .echo_load(echo_load), .echo_byte(echo_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .done(done), .start_addr(start_addr), .boot_en(boot_en)
    );

    sbl_tx u_tx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .load(echo_load), .load_byte(echo_byte),
        .txd(txd), .busy(tx_busy)
    );
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          txd,
    input logic          boot_en,
    input logic          tx_busy
);
    logic          seen_q;
    logic [AW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (mem_we) begin
            seen_q <= 1'b1;
            last_q <= mem_addr;
        end
    end

    a_r1_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_en |-> (!mem_we && !done && txd));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r7_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_we);

    a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && seen_q) |-> (mem_addr == last_q + 1'b1));

    a_r3_tx_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
endmodule

bind serial_boot_loader sbl_checker #(.AW(AW)) u_sbl_checker (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .done(done), .txd(txd), .boot_en(boot_en), .tx_busy(tx_busy)
);

// File: tb/test_serial_boot_loader.sv
module test_serial_boot_loader;
    localparam int AW      = 16;
    localparam int DIV     = 4;
    localparam int BIT_CLK = 16 * DIV;
    localparam int WD      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_pins = 4'b0000;
    logic        os_tick = 1'b0;
    logic        rxd = 1'b1;
    logic        txd;
    logic        mem_we;
    logic [AW-1:0] mem_addr;
    logic [23:0] mem_data;
    logic        done;
    logic [23:0] start_addr;

    int nchecks = 0;
    int nerr = 0;
    int div_cnt = 0;

    logic [7:0]    exp_echo[$];
    logic [AW-1:0] exp_addr[$];
    logic [23:0]   exp_data[$];

    serial_boot_loader #(.AW(AW)) i_serial_boot_loader (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .os_tick(os_tick),
        .rxd(rxd), .txd(txd), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .done(done), .start_addr(start_addr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        os_tick <= (div_cnt == DIV - 1);
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Reference comparison on every clock: writes against the expected queue,
    // and done must not come while writes are still expected.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_addr.size() == 0) begin
                    check("R7 unexpected write", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    check("R6 write address", 32'(mem_addr), 32'(exp_addr.pop_front()));
                    check("R6 write data", 32'(mem_data), 32'(exp_data.pop_front()));
                end
            end
            if (done && exp_addr.size() != 0)
                check("R7 done before all words", 32'(exp_addr.size()), 32'd0);
        end
    end

    // Decoder for the echo on txd
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] b;
                repeat (BIT_CLK / 2) @(negedge clk);
                check("R3 echo start bit", 32'(txd), 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CLK) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BIT_CLK) @(negedge clk);
                check("R3 echo stop bit", 32'(txd), 32'd1);
                if (exp_echo.size() == 0)
                    check("R3 unexpected echo (R1/R7/R9)", 32'(b), 32'h100);
                else
                    check("R3 echo byte", 32'(b), 32'(exp_echo.pop_front()));
            end
        end
    end

    task automatic send(input logic [7:0] b, input logic stop_bit);
        rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd = stop_bit;
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
    endtask

    task automatic send_echoed(input logic [7:0] b);
        exp_echo.push_back(b);
        send(b, 1'b1);
    endtask

    task automatic send_word(input logic [23:0] w, input logic [AW-1:0] a);
        exp_addr.push_back(a);
        exp_data.push_back(w);
        send_echoed(w[7:0]);
        send_echoed(w[15:8]);
        send_echoed(w[23:16]);
    endtask

    task automatic do_reset(input logic [3:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_pins = m;
        rxd = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mode_pins = ~m;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        nerr++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        // Scenario A: non-boot mode stays silent (R1)
        do_reset(4'b0101);
        check("R1 reset txd idle", 32'(txd), 32'd1);
        check("R1 reset done low", 32'(done), 32'd0);
        send(8'h01, 1'b1);
        send(8'h00, 1'b1);
        send(8'h00, 1'b1);
        repeat (800) @(negedge clk);
        check("R1 no done when not booting", 32'(done), 32'd0);
        check("R1 txd stays high", 32'(txd), 32'd1);

        // Scenario B: full load in mode 0010
        do_reset(4'b0010);
        check("R1 reset mem_we low", 32'(mem_we), 32'd0);
        check("R7 reset done low", 32'(done), 32'd0);
        send_echoed(8'h03);   // R4 length = 3, least significant byte first
        send_echoed(8'h00);
        send_echoed(8'h00);
        check("R4 not done after length", 32'(done), 32'd0);
        send_echoed(8'h34);   // R5 address = 0x001234
        send_echoed(8'h12);
        send_echoed(8'h00);
        check("R5 start_addr captured", 32'(start_addr), 32'h0000_1234);
        // R2 short low glitch is not a start bit
        rxd = 1'b0;
        repeat (2 * DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        // R9 frame with a bad stop bit is dropped
        send(8'h5A, 1'b0);
        send_word(24'hA1B2C3, 16'h1234);
        send_word(24'h00FF10, 16'h1235);
        send_word(24'h7E5A81, 16'h1236);
        check("R7 done after last word", 32'(done), 32'd1);
        check("R6 all writes seen", 32'(exp_addr.size()), 32'd0);
        repeat (800) @(negedge clk);
        check("R3 all echoes seen (R2/R9 nothing extra)", 32'(exp_echo.size()), 32'd0);
        send(8'h99, 1'b1);    // R7 ignored after done
        repeat (800) @(negedge clk);
        check("R7 done stays high", 32'(done), 32'd1);
        check("R5 start_addr held", 32'(start_addr), 32'h0000_1234);

        // Scenario C: zero length in mode 1010 (R8)
        do_reset(4'b1010);
        send_echoed(8'h00);
        send_echoed(8'h00);
        send_echoed(8'h00);
        check("R8 done right after zero length", 32'(done), 32'd1);
        repeat (800) @(negedge clk);
        check("R8 zero-length echoes seen", 32'(exp_echo.size()), 32'd0);
        send(8'h11, 1'b1);
        send(8'h22, 1'b1);
        repeat (800) @(negedge clk);
        check("R8 start_addr stays zero", 32'(start_addr), 32'd0);
        check("R8 done stays high", 32'(done), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule